// File: doc/BRIEF.md
# Deep Power-Down Sequencer

This controller-side sequencer moves a single SDRAM device into its hibernate state and later wakes it. In that state the device keeps no data. An entry request carries a device-select value, so that one device on a shared command bus can be addressed. The sequencer first checks three configuration inputs: command/address parity, the CS-to-command latency feature and gear-down. If any of them is enabled, it refuses the request and flags an error. Otherwise it issues one mode-register write that sets the enable bit of the power-down mode register.

After that write, the sequencer drives only deselect commands for a first interval. It then stops driving the command bus. The clock keeps running until a second, longer interval has passed since the write, and then the sequencer turns off the clock enable. From the parked state, an exit request does the following in order:

- turns the clock back on for a set number of cycles;
- drops CKE;
- drops CS_n;
- raises CKE again.

A reset request overrides everything. It holds the device reset low and marks the device as needing full initialisation.

Entry requests that arrive while the sequencer is busy are kept and then served from idle. All intervals are counted in controller clock cycles.

Top module: `dpd_seq`

## Requirements
- R1: After reset the pins are at rest: cmd_valid=0, cke=1, cs_n=1, clk_en=1, dram_rst_n=1, ack=0, err=0. An entry request with all three feature inputs low produces exactly one mode-register write. The write has cmd_valid=1, cmd_code=2'b01, cmd_mr=4, cmd_addr with only bit 1 set, and cmd_dev equal to the req_dev captured with the request. It appears in the second cycle after the request is sampled; the cycle before it still shows the rest pins.
- R2: If any of cfg_parity_en, cfg_cs_lat_en or cfg_geardown_en is high when the request is checked, no write is issued. err is high for exactly one cycle, one cycle after the check, and the pins stay at rest.
- R3: For T_MPED cycles after the write cycle, cmd_valid=1 with cmd_code=2'b00 (deselect).
- R4: After those cycles, cmd_valid=0. clk_en stays 1 for T_CKMPE cycles after the write cycle in total, then goes to 0 and stays there while parked.
- R5: ack is a one-cycle pulse in the first parked cycle and in the cycle right after the exit sequence.
- R6: An exit request while parked gives the following, then all pins at rest with ack:
  - T_CLKON cycles with clk_en=1, cke=1, cs_n=1;
  - then T_STEP cycles with cke=0, cs_n=1;
  - then T_STEP cycles with cke=0, cs_n=0;
  - then T_STEP cycles with cke=1, cs_n=0.
- R7: An exit request outside the parked state leaves every output unchanged.
- R8: A reset request gives T_RST cycles of dram_rst_n=0, cke=0, cs_n=1 and cmd_valid=0, then the rest state. reinit_req is high from the first reset cycle until init_done. A reset request wins over an exit request in the same cycle. A held entry request is discarded.
- R9: mem_invalid rises with the write cycle. It stays high through parking, exit and reset, and clears in the cycle after init_done.
- R10: An entry request that arrives during entry, exit or parking has no visible effect at that time. It is started once the sequencer reaches idle: the check cycle follows the first idle cycle, and the write carries the req_dev given with that request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_enter | input | 1 | Entry request, one-cycle pulse |
| req_dev | input | DEV_W | Device select given with the entry request |
| req_exit | input | 1 | Exit request, honoured only while parked |
| req_reset | input | 1 | Drive device reset, overrides all states |
| init_done | input | 1 | Device re-initialised; clears status flags |
| cfg_parity_en | input | 1 | Command/address parity is enabled |
| cfg_cs_lat_en | input | 1 | CS-to-command latency is enabled |
| cfg_geardown_en | input | 1 | Gear-down mode is enabled |
| ack | output | 1 | Pulse on reaching parked and on finishing exit |
| err | output | 1 | Pulse when entry is refused |
| cmd_valid | output | 1 | Command bus driven this cycle |
| cmd_code | output | 2 | 00 deselect, 01 mode-register write |
| cmd_mr | output | MR_W | Mode register number of the write |
| cmd_addr | output | ADDR_W | Address/data of the write |
| cmd_dev | output | DEV_W | Device addressed by the write |
| cke | output | 1 | Clock enable pin |
| cs_n | output | 1 | Chip select pin, active low |
| clk_en | output | 1 | Gate for the device clock |
| dram_rst_n | output | 1 | Device reset pin, active low |
| mem_invalid | output | 1 | Device contents are not valid |
| reinit_req | output | 1 | Device needs full initialisation |

## Verification
Two functions can meet in the same cycle: waking the device from the parked state and resetting it. The bench raises req_exit and req_reset on the same edge while parked. It expects no clock re-enable step and no CKE/CS_n exit pattern. Instead it expects T_RST cycles of low reset with CKE low, then rest pins with reinit_req set. Just before that, a parked entry request is raised so the bench can also judge that the reset drops the held request.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_CHECK,
    S_ISSUE_MRS,
    S_WAIT_MPED,
    S_WAIT_CKMPE,
    S_PARKED,
    S_EXIT_CLK_ON,
    S_EXIT_CKE_LO,
    S_EXIT_CS_LO,
    S_EXIT_CKE_HI,
    S_DONE,
    S_RST_HOLD
  } dpd_state_e;

  localparam logic [1:0] CMD_DES = 2'b00;
  localparam logic [1:0] CMD_MRS = 2'b01;

  typedef struct packed {
    logic       cmd_valid;
    logic [1:0] cmd_code;
    logic       cke;
    logic       cs_n;
    logic       clk_en;
    logic       rst_n;
  } pin_s;

  localparam pin_s PINS_REST = '{cmd_valid: 1'b0, cmd_code: CMD_DES, cke: 1'b1,
                                 cs_n: 1'b1, clk_en: 1'b1, rst_n: 1'b1};

  function automatic pin_s pins_for(dpd_state_e s);
    pin_s p;
    p = PINS_REST;
    case (s)
      S_ISSUE_MRS: begin
        p.cmd_valid = 1'b1;
        p.cmd_code  = CMD_MRS;
      end
      S_WAIT_MPED:   p.cmd_valid = 1'b1;
      S_PARKED:      p.clk_en = 1'b0;
      S_EXIT_CKE_LO: p.cke = 1'b0;
      S_EXIT_CS_LO: begin
        p.cke  = 1'b0;
        p.cs_n = 1'b0;
      end
      S_EXIT_CKE_HI: p.cs_n = 1'b0;
      S_RST_HOLD: begin
        p.cke   = 1'b0;
        p.rst_n = 1'b0;
      end
      default: p = PINS_REST;
    endcase
    return p;
  endfunction

endpackage

// File: rtl/dpd_feature_gate.sv
module dpd_feature_gate #(
  parameter int NFEAT = 3
) (
  input  logic [NFEAT-1:0] feat_on,
  output logic             any_on
);
  logic [NFEAT:0] chain;
  assign chain[0] = 1'b0;
  for (genvar i = 0; i < NFEAT; i++) begin : g_or
    assign chain[i+1] = chain[i] | feat_on[i];
  end
  assign any_on = chain[NFEAT];
endmodule

// File: rtl/dpd_interval_ctr.sv
module dpd_interval_ctr #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q;
  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end
  assign expired = (cnt_q == '0);
endmodule

// File: rtl/dpd_out_reg.sv
module dpd_out_reg
  import dpd_pkg::*;
#(
  parameter int DEV_W      = 4,
  parameter int ADDR_W     = 18,
  parameter int MR_W       = 3,
  parameter int MR_INDEX   = 4,
  parameter int ENABLE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  dpd_state_e        state_q,
  input  dpd_state_e        state_d,
  input  logic              refuse,
  input  logic              init_done,
  input  logic [DEV_W-1:0]  tgt_dev,
  output logic              ack,
  output logic              err,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [MR_W-1:0]   cmd_mr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DEV_W-1:0]  cmd_dev,
  output logic              cke,
  output logic              cs_n,
  output logic              clk_en,
  output logic              dram_rst_n,
  output logic              mem_invalid,
  output logic              reinit_req
);
  localparam logic [ADDR_W-1:0] ENTRY_WORD = ADDR_W'(1) << ENABLE_BIT;

  pin_s pins_q;
  logic writing;

  assign writing = (state_d == S_ISSUE_MRS);

  always_ff @(posedge clk) begin
    if (rst) begin
      pins_q      <= PINS_REST;
      ack         <= 1'b0;
      err         <= 1'b0;
      cmd_mr      <= '0;
      cmd_addr    <= '0;
      cmd_dev     <= '0;
      mem_invalid <= 1'b0;
      reinit_req  <= 1'b0;
    end else begin
      pins_q   <= pins_for(state_d);
      ack      <= ((state_d == S_PARKED) && (state_q != S_PARKED)) || (state_d == S_DONE);
      err      <= refuse;
      cmd_mr   <= writing ? MR_W'(MR_INDEX) : '0;
      cmd_addr <= writing ? ENTRY_WORD : '0;
      cmd_dev  <= writing ? tgt_dev : '0;
      if (writing)
        mem_invalid <= 1'b1;
      else if (init_done)
        mem_invalid <= 1'b0;
      if (state_d == S_RST_HOLD)
        reinit_req <= 1'b1;
      else if (init_done)
        reinit_req <= 1'b0;
    end
  end

  assign cmd_valid  = pins_q.cmd_valid;
  assign cmd_code   = pins_q.cmd_code;
  assign cke        = pins_q.cke;
  assign cs_n       = pins_q.cs_n;
  assign clk_en     = pins_q.clk_en;
  assign dram_rst_n = pins_q.rst_n;
endmodule

// File: rtl/dpd_seq.sv
module dpd_seq
  import dpd_pkg::*;
#(
  parameter int DEV_W      = 4,
  parameter int ADDR_W     = 18,
  parameter int MR_W       = 3,
  parameter int MR_INDEX   = 4,
  parameter int ENABLE_BIT = 1,
  parameter int T_MPED     = 8,
  parameter int T_CKMPE    = 16,
  parameter int T_CLKON    = 4,
  parameter int T_STEP     = 3,
  parameter int T_RST      = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_enter,
  input  logic [DEV_W-1:0]  req_dev,
  input  logic              req_exit,
  input  logic              req_reset,
  input  logic              init_done,
  input  logic              cfg_parity_en,
  input  logic              cfg_cs_lat_en,
  input  logic              cfg_geardown_en,
  output logic              ack,
  output logic              err,
  output logic              cmd_valid,
  output logic [1:0]        cmd_code,
  output logic [MR_W-1:0]   cmd_mr,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [DEV_W-1:0]  cmd_dev,
  output logic              cke,
  output logic              cs_n,
  output logic              clk_en,
  output logic              dram_rst_n,
  output logic              mem_invalid,
  output logic              reinit_req
);
  localparam int NFEAT  = 3;
  localparam int T_TAIL = (T_CKMPE > T_MPED) ? (T_CKMPE - T_MPED) : 1;
  localparam int TM1    = (T_MPED > T_TAIL) ? T_MPED : T_TAIL;
  localparam int TM2    = (T_CLKON > T_STEP) ? T_CLKON : T_STEP;
  localparam int TM3    = (TM1 > TM2) ? TM1 : TM2;
  localparam int TMAX   = (TM3 > T_RST) ? TM3 : T_RST;
  localparam int CW     = $clog2(TMAX + 1);

  dpd_state_e       state_q, state_d;
  logic             refuse;
  logic             feat_bad;
  logic             expired;
  logic             start;
  logic             pend_q;
  logic [DEV_W-1:0] pend_dev_q;
  logic [DEV_W-1:0] tgt_q;
  logic [CW-1:0]    load_val;

  function automatic logic [CW-1:0] len_m1(dpd_state_e s);
    case (s)
      S_WAIT_MPED:   return CW'(T_MPED - 1);
      S_WAIT_CKMPE:  return CW'(T_TAIL - 1);
      S_EXIT_CLK_ON: return CW'(T_CLKON - 1);
      S_EXIT_CKE_LO,
      S_EXIT_CS_LO,
      S_EXIT_CKE_HI: return CW'(T_STEP - 1);
      S_RST_HOLD:    return CW'(T_RST - 1);
      default:       return '0;
    endcase
  endfunction

  dpd_feature_gate #(.NFEAT(NFEAT)) u_gate (
    .feat_on ({cfg_geardown_en, cfg_cs_lat_en, cfg_parity_en}),
    .any_on  (feat_bad)
  );

  assign start = pend_q | req_enter;

  always_comb begin
    state_d = state_q;
    refuse  = 1'b0;
    if (req_reset) begin
      state_d = S_RST_HOLD;
    end else begin
      case (state_q)
        S_IDLE:        if (start) state_d = S_CHECK;
        S_CHECK: begin
          if (feat_bad) begin
            state_d = S_IDLE;
            refuse  = 1'b1;
          end else begin
            state_d = S_ISSUE_MRS;
          end
        end
        S_ISSUE_MRS:   state_d = S_WAIT_MPED;
        S_WAIT_MPED:   if (expired) state_d = S_WAIT_CKMPE;
        S_WAIT_CKMPE:  if (expired) state_d = S_PARKED;
        S_PARKED:      if (req_exit) state_d = S_EXIT_CLK_ON;
        S_EXIT_CLK_ON: if (expired) state_d = S_EXIT_CKE_LO;
        S_EXIT_CKE_LO: if (expired) state_d = S_EXIT_CS_LO;
        S_EXIT_CS_LO:  if (expired) state_d = S_EXIT_CKE_HI;
        S_EXIT_CKE_HI: if (expired) state_d = S_DONE;
        S_DONE:        state_d = S_IDLE;
        S_RST_HOLD:    if (expired) state_d = S_IDLE;
        default:       state_d = S_IDLE;
      endcase
    end
  end

  assign load_val = len_m1(state_d);

  dpd_interval_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (state_d != state_q),
    .load_val (load_val),
    .expired  (expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= S_IDLE;
      pend_q     <= 1'b0;
      pend_dev_q <= '0;
      tgt_q      <= '0;
    end else begin
      state_q <= state_d;
      if (req_reset || state_q == S_IDLE) begin
        pend_q <= 1'b0;
      end else if (req_enter) begin
        pend_q     <= 1'b1;
        pend_dev_q <= req_dev;
      end
      if (state_q == S_IDLE && state_d == S_CHECK)
        tgt_q <= req_enter ? req_dev : pend_dev_q;
    end
  end

  dpd_out_reg #(
    .DEV_W(DEV_W), .ADDR_W(ADDR_W), .MR_W(MR_W),
    .MR_INDEX(MR_INDEX), .ENABLE_BIT(ENABLE_BIT)
  ) u_out (
    .clk         (clk),
    .rst         (rst),
    .state_q     (state_q),
    .state_d     (state_d),
    .refuse      (refuse),
    .init_done   (init_done),
    .tgt_dev     (tgt_q),
    .ack         (ack),
    .err         (err),
    .cmd_valid   (cmd_valid),
    .cmd_code    (cmd_code),
    .cmd_mr      (cmd_mr),
    .cmd_addr    (cmd_addr),
    .cmd_dev     (cmd_dev),
    .cke         (cke),
    .cs_n        (cs_n),
    .clk_en      (clk_en),
    .dram_rst_n  (dram_rst_n),
    .mem_invalid (mem_invalid),
    .reinit_req  (reinit_req)
  );
endmodule

// File: rtl/dpd_seq_chk.sv
module dpd_seq_chk
  import dpd_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       cfg_parity_en,
  input logic       cfg_cs_lat_en,
  input logic       cfg_geardown_en,
  input logic       cmd_valid,
  input logic [1:0] cmd_code,
  input logic       cke,
  input logic       cs_n,
  input logic       clk_en,
  input logic       dram_rst_n,
  input logic       ack,
  input logic       err
);
  AST_MRS_NEEDS_FEATURES_OFF: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_code == CMD_MRS) |-> !$past(cfg_parity_en || cfg_cs_lat_en || cfg_geardown_en)); // R2
  AST_REFUSE_NO_COMMAND: assert property (@(posedge clk) disable iff (rst)
    err |-> !cmd_valid); // R2
  AST_DESELECT_AFTER_MRS: assert property (@(posedge clk) disable iff (rst)
    ($past(cmd_valid) && $past(cmd_code) == CMD_MRS) |-> (cmd_valid && cmd_code == CMD_DES)); // R3
  AST_CLOCK_OFF_ONLY_PARKED: assert property (@(posedge clk) disable iff (rst)
    !clk_en |-> (!cmd_valid && dram_rst_n && cke && cs_n)); // R4
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (rst)
    ack |=> !ack); // R5
  AST_CS_FALLS_WITH_CKE_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> !cke); // R6
  AST_CKE_RISE_ORDER: assert property (@(posedge clk) disable iff (rst)
    $rose(cke) |-> (!cs_n || $past(!dram_rst_n))); // R6
  AST_RESET_HOLDS_CKE: assert property (@(posedge clk) disable iff (rst)
    !dram_rst_n |-> !cke); // R8
endmodule

bind dpd_seq dpd_seq_chk u_chk (
  .clk             (clk),
  .rst             (rst),
  .cfg_parity_en   (cfg_parity_en),
  .cfg_cs_lat_en   (cfg_cs_lat_en),
  .cfg_geardown_en (cfg_geardown_en),
  .cmd_valid       (cmd_valid),
  .cmd_code        (cmd_code),
  .cke             (cke),
  .cs_n            (cs_n),
  .clk_en          (clk_en),
  .dram_rst_n      (dram_rst_n),
  .ack             (ack),
  .err             (err)
);

// File: tb/tb_dpd_seq.sv
`timescale 1ns/1ps
module tb_dpd_seq;
  localparam int DEV_W = 4, ADDR_W = 18, MR_W = 3;
  localparam int T_MPED = 3, T_CKMPE = 6, T_CLKON = 2, T_STEP = 2, T_RST = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_enter = 1'b0, req_exit = 1'b0, req_reset = 1'b0, init_done = 1'b0;
  logic [DEV_W-1:0] req_dev = '0;
  logic cfg_parity_en = 1'b0, cfg_cs_lat_en = 1'b0, cfg_geardown_en = 1'b0;
  logic ack, err, cmd_valid, cke, cs_n, clk_en, dram_rst_n, mem_invalid, reinit_req;
  logic [1:0] cmd_code;
  logic [MR_W-1:0] cmd_mr;
  logic [ADDR_W-1:0] cmd_addr;
  logic [DEV_W-1:0] cmd_dev;

  always #2 clk = ~clk;

  dpd_seq #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .MR_W(MR_W), .T_MPED(T_MPED),
            .T_CKMPE(T_CKMPE), .T_CLKON(T_CLKON), .T_STEP(T_STEP), .T_RST(T_RST)) dut (
    .clk(clk), .rst(rst), .req_enter(req_enter), .req_dev(req_dev), .req_exit(req_exit),
    .req_reset(req_reset), .init_done(init_done), .cfg_parity_en(cfg_parity_en),
    .cfg_cs_lat_en(cfg_cs_lat_en), .cfg_geardown_en(cfg_geardown_en), .ack(ack), .err(err),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .cmd_mr(cmd_mr), .cmd_addr(cmd_addr),
    .cmd_dev(cmd_dev), .cke(cke), .cs_n(cs_n), .clk_en(clk_en), .dram_rst_n(dram_rst_n),
    .mem_invalid(mem_invalid), .reinit_req(reinit_req));

  typedef struct packed {
    logic v; logic [1:0] code; logic [MR_W-1:0] mr; logic [ADDR_W-1:0] addr;
    logic [DEV_W-1:0] dev; logic ke; logic cs; logic ce; logic rn;
    logic ak; logic er; logic minv; logic rinit;
  } snap_t;

  snap_t expq[$];
  string tagq[$];
  int total = 0, bad = 0;
  logic m_minv = 1'b0, m_rinit = 1'b0;
  logic finished = 1'b0;

  function automatic snap_t mk(logic v, logic [1:0] c, logic ke, logic cs, logic ce,
                               logic rn, logic ak, logic er);
    snap_t s;
    s = '0;
    s.v = v; s.code = c; s.ke = ke; s.cs = cs; s.ce = ce; s.rn = rn;
    s.ak = ak; s.er = er; s.minv = m_minv; s.rinit = m_rinit;
    return s;
  endfunction

  function automatic snap_t rest(logic ak, logic er);
    return mk(1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, ak, er);
  endfunction

  function automatic snap_t got_now();
    snap_t s;
    s.v = cmd_valid; s.code = cmd_code; s.mr = cmd_mr; s.addr = cmd_addr; s.dev = cmd_dev;
    s.ke = cke; s.cs = cs_n; s.ce = clk_en; s.rn = dram_rst_n; s.ak = ack; s.er = err;
    s.minv = mem_invalid; s.rinit = reinit_req;
    return s;
  endfunction

  task automatic push(snap_t s, string t, int n);
    for (int i = 0; i < n; i++) begin
      expq.push_back(s);
      tagq.push_back(t);
    end
  endtask

  task automatic check(snap_t g, snap_t e, string t);
    total++;
    if (g !== e) begin
      bad++;
      $display("FAIL %s: got=%h exp=%h", t, g, e);
    end
  endtask

  // monitor: one expected item per clock, sampled 1 ns after the edge
  always begin
    @(posedge clk);
    #1;
    if (expq.size() > 0) begin
      snap_t e;
      string t;
      e = expq.pop_front();
      t = tagq.pop_front();
      check(got_now(), e, t);
    end
  end

  task automatic drain();
    while (expq.size() > 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic push_entry(logic [DEV_W-1:0] d);
    snap_t s;
    push(rest(1'b0, 1'b0), "R1 check cycle", 1);
    m_minv = 1'b1;
    s = mk(1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0);
    s.mr = 3'd4; s.addr = 18'h2; s.dev = d;
    push(s, "R1 entry write", 1);
    push(mk(1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), "R3 deselect", T_MPED);
    push(rest(1'b0, 1'b0), "R4 clock held", T_CKMPE - T_MPED);
    push(mk(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0), "R5 ack parked", 1);
    push(mk(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), "R4 parked clk off", 3);
  endtask

  task automatic push_exit();
    push(rest(1'b0, 1'b0), "R6 clock back on", T_CLKON);
    push(mk(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0), "R6 cke low", T_STEP);
    push(mk(1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0), "R6 cs low", T_STEP);
    push(mk(1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0), "R6 cke high", T_STEP);
    push(rest(1'b1, 1'b0), "R5 ack done", 1);
  endtask

  task automatic do_entry(logic [DEV_W-1:0] d);
    req_enter = 1'b1; req_dev = d;
    push_entry(d);
    @(negedge clk);
    req_enter = 1'b0;
    drain();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(got_now(), rest(1'b0, 1'b0), "R1 reset state");

    // exit request while idle is ignored
    req_exit = 1'b1;
    push(rest(1'b0, 1'b0), "R7 exit ignored in idle", 4);
    @(negedge clk);
    req_exit = 1'b0;
    drain();

    // refused entry, one feature at a time
    for (int f = 0; f < 3; f++) begin
      cfg_parity_en = (f == 0); cfg_cs_lat_en = (f == 1); cfg_geardown_en = (f == 2);
      req_enter = 1'b1; req_dev = 4'h5;
      push(rest(1'b0, 1'b0), "R2 check cycle", 1);
      push(rest(1'b0, 1'b1), "R2 err pulse", 1);
      push(rest(1'b0, 1'b0), "R2 no write after refuse", 3);
      @(negedge clk);
      req_enter = 1'b0;
      drain();
    end
    cfg_parity_en = 1'b0; cfg_cs_lat_en = 1'b0; cfg_geardown_en = 1'b0;

    do_entry(4'hA);

    // exit, then clear status
    req_exit = 1'b1;
    push_exit();
    push(rest(1'b0, 1'b0), "R9 invalid kept after exit", 2);
    @(negedge clk);
    req_exit = 1'b0;
    drain();
    init_done = 1'b1;
    m_minv = 1'b0;
    push(rest(1'b0, 1'b0), "R9 cleared by init_done", 2);
    @(negedge clk);
    init_done = 1'b0;
    drain();

    // held entry request during exit
    do_entry(4'h3);
    req_exit = 1'b1;
    push_exit();
    push(rest(1'b0, 1'b0), "R10 idle before held entry", 1);
    push_entry(4'hC);
    @(negedge clk);
    req_exit = 1'b0;
    repeat (3) @(negedge clk);
    req_enter = 1'b1; req_dev = 4'hC;
    @(negedge clk);
    req_enter = 1'b0; req_dev = 4'h0;
    drain();

    // parked entry request has no visible effect, then reset collides with exit
    req_enter = 1'b1; req_dev = 4'h7;
    push(mk(1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0), "R10 entry held while parked", 2);
    @(negedge clk);
    req_enter = 1'b0;
    drain();
    req_exit = 1'b1; req_reset = 1'b1;
    m_rinit = 1'b1;
    push(mk(1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0), "R8 reset beats exit", T_RST);
    push(rest(1'b0, 1'b0), "R8 idle after reset, held entry dropped", 4);
    @(negedge clk);
    req_exit = 1'b0; req_reset = 1'b0;
    drain();
    init_done = 1'b1;
    m_rinit = 1'b0; m_minv = 1'b0;
    push(rest(1'b0, 1'b0), "R8 reinit cleared", 2);
    @(negedge clk);
    init_done = 1'b0;
    drain();

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule